// File: doc/BRIEF.md
# Permission-Aware Cache Tag Directory

This block is the tag side of a set-associative coherent cache. Every way of every set holds a line tag, a three-bit access-permission state and a lock-owner context. A requester presents one operation per cycle with a line-aligned address. The operations cover a permission-checked access, a raw tag lookup, a set-availability query, allocation, deallocation, a victim probe, a permission write, and setting, clearing or testing the lock owner. The data array and the coherence controller are outside the block. Replacement is a true-LRU age order per set.

An operation is presented as one `req_valid` cycle. It is decoded against the state held before that clock edge. Any state change and the registered response both take effect at that edge, so the response is visible in the cycle after the request. The block accepts a request every cycle and has no back-pressure, so no ready signal exists. A `req_valid` pulse always produces exactly one `rsp_valid` pulse one cycle later, and a requester that must stall has to hold the request back itself. The response fields are zero whenever `rsp_valid` is low.

Top module: `permtag_dir`

## Requirements
- R1: The set is `req_addr[IDX_LSB +: log2(NUM_SETS)]` and the stored tag is `req_addr[ADDR_W-1:IDX_LSB]`. Lines in different sets never match each other, and the low `IDX_LSB` address bits are ignored.
- R2: `rsp_valid` is high exactly one cycle after `req_valid` and low otherwise. While `rsp_valid` is low every response field is zero. A cycle without `req_valid` changes no state. Reset empties every way.
- R3: Operation encodings are ACCESS=0, LOOKUP_RAW=1, AVAIL=2, ALLOC=3, DEALLOC=4, PROBE=5, LOCK_SET=6, LOCK_CLR=7, LOCK_TEST=8 and SET_PERM=9; other codes change nothing and return zeros. Permission encodings are NOTPRESENT=0, INVALID=1, READ_ONLY=2, READ_WRITE=3 and BUSY=4. ACCESS reports `rsp_hit` only for a tag match whose permission is not NOTPRESENT, while LOOKUP_RAW reports any tag match in a filled way. On a hit, `rsp_way` gives the matching way.
- R4: Request types are LOAD=0, IFETCH=1, STORE=2 and ATOMIC=3. An ACCESS hit on READ_WRITE grants every type. A hit on READ_ONLY grants only LOAD and IFETCH. Every other hit is denied.
- R5: Every ACCESS hit marks its way most recently used, whether or not access is granted.
- R6: AVAIL sets `rsp_avail` when a filled way already holds the tag, or when some way is empty or NOTPRESENT.
- R7: ALLOC writes a way that already holds the tag in NOTPRESENT; failing that, it writes the lowest-numbered empty or NOTPRESENT way. It stores the tag, sets the permission to INVALID and the lock owner to all-ones (no owner), and reports the way. It marks that way most recently used only when `req_touch` is 1. If no way is free, or if the tag is already present with a permission other than NOTPRESENT, it raises `rsp_error` and changes nothing.
- R8: DEALLOC of a line that is present (permission not NOTPRESENT) empties its way and reports a hit; afterwards, lookups of that tag miss. DEALLOC of a line that is not present changes nothing and reports no hit.
- R9: LOCK_SET writes `req_ctx` as the lock owner of a present line, and LOCK_CLR writes all-ones. LOCK_TEST sets `rsp_lock_match` only when the line is present and its owner equals `req_ctx`.
- R10: For ACCESS and LOOKUP_RAW, `rsp_not_busy` is 1 when the tag matches a filled way whose permission is not BUSY.
- R11: PROBE returns in `rsp_way` the least-recently-used way of the set, and in `rsp_victim_addr` that way's line address (tag with zero offset). Out of reset, way 0 is the most recently used and the highest way is the least recently used.
- R12: SET_PERM writes `req_perm` into a filled way whose tag matches, whatever its current permission, and reports the hit and the way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation present this cycle |
| req_op | input | 4 | Operation code |
| req_addr | input | ADDR_W | Line-aligned address |
| req_type | input | 2 | Request type for ACCESS |
| req_ctx | input | CTX_W | Context for LOCK_SET and LOCK_TEST |
| req_perm | input | 3 | Permission for SET_PERM |
| req_touch | input | 1 | ALLOC updates the LRU order |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 1 | Tag hit as defined for the operation |
| rsp_way | output | log2(NUM_WAYS) | Hit, allocated or victim way |
| rsp_grant | output | 1 | ACCESS permitted |
| rsp_avail | output | 1 | Set can take the address |
| rsp_error | output | 1 | ALLOC refused |
| rsp_lock_match | output | 1 | LOCK_TEST owner match |
| rsp_not_busy | output | 1 | Matching line not BUSY |
| rsp_victim_addr | output | ADDR_W | Victim line address for PROBE |

## Verification
A corrupted permission field shows up on the first ACCESS to that line, one cycle later, as a wrong grant, hit or not-busy bit. A stuck valid bit or a bad tag appears as a phantom or missing hit, or as a wrong AVAIL answer. An LRU age order that is not a permutation, or that was updated at the wrong time, stays hidden until the next PROBE of that set. For that reason, probes are placed directly after touching and non-touching allocations and after denied accesses. A lock field that allocation left uncleared is caught by a LOCK_TEST with the all-ones context right after ALLOC.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

  typedef enum logic [2:0] {
    PERM_NOTPRESENT = 3'd0,
    PERM_INVALID    = 3'd1,
    PERM_READ_ONLY  = 3'd2,
    PERM_READ_WRITE = 3'd3,
    PERM_BUSY       = 3'd4
  } perm_e;

  typedef enum logic [1:0] {
    RQ_LOAD   = 2'd0,
    RQ_IFETCH = 2'd1,
    RQ_STORE  = 2'd2,
    RQ_ATOMIC = 2'd3
  } rqtype_e;

  typedef enum logic [3:0] {
    OP_ACCESS     = 4'd0,
    OP_LOOKUP_RAW = 4'd1,
    OP_AVAIL      = 4'd2,
    OP_ALLOC      = 4'd3,
    OP_DEALLOC    = 4'd4,
    OP_PROBE      = 4'd5,
    OP_LOCK_SET   = 4'd6,
    OP_LOCK_CLR   = 4'd7,
    OP_LOCK_TEST  = 4'd8,
    OP_SET_PERM   = 4'd9
  } op_e;

  // Read-write grants everything; read-only grants reads only.
  function automatic logic perm_grants(perm_e p, rqtype_e t);
    logic ok;
    ok = 1'b0;
    if (p == PERM_READ_WRITE) ok = 1'b1;
    else if (p == PERM_READ_ONLY && (t == RQ_LOAD || t == RQ_IFETCH)) ok = 1'b1;
    return ok;
  endfunction

endpackage

// File: rtl/tagdir_way_cmp.sv
module tagdir_way_cmp
  import tagdir_pkg::*;
#(
  parameter int TAG_W = 12
) (
  input  logic             way_valid,
  input  logic [TAG_W-1:0] way_tag,
  input  perm_e            way_perm,
  input  logic [TAG_W-1:0] req_tag,
  output logic             raw_match,
  output logic             live_match,
  output logic             is_free
);
  always_comb begin
    raw_match  = way_valid && (way_tag == req_tag);
    live_match = raw_match && (way_perm != PERM_NOTPRESENT);
    is_free    = !way_valid || (way_perm == PERM_NOTPRESENT);
  end
endmodule

// File: rtl/tagdir_pick_first.sv
module tagdir_pick_first #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/tagdir_lru.sv
module tagdir_lru #(
  parameter int NUM_SETS = 4,
  parameter int NUM_WAYS = 4,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [SET_W-1:0] query_set,
  output logic [WAY_W-1:0] victim_way
);
  // Age 0 = most recent, NUM_WAYS-1 = least recent; each set holds a permutation.
  logic [WAY_W-1:0] age [NUM_SETS][NUM_WAYS];
  logic [WAY_W-1:0] touched_age;

  assign touched_age = age[touch_set][touch_way];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < NUM_WAYS; w++)
          age[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age[touch_set][w] <= '0;
        else if (age[touch_set][w] < touched_age)
          age[touch_set][w] <= age[touch_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_way = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (age[query_set][w] == WAY_W'(NUM_WAYS - 1)) victim_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/permtag_dir.sv
module permtag_dir
  import tagdir_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_SETS = 4,
  parameter int NUM_WAYS = 4,
  parameter int IDX_LSB  = 4,
  parameter int CTX_W    = 4,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int TAG_W = ADDR_W - IDX_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_type,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic [2:0]        req_perm,
  input  logic              req_touch,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic              rsp_grant,
  output logic              rsp_avail,
  output logic              rsp_error,
  output logic              rsp_lock_match,
  output logic              rsp_not_busy,
  output logic [ADDR_W-1:0] rsp_victim_addr
);
  localparam logic [CTX_W-1:0] NO_OWNER = '1;

  // Line state
  logic             ent_valid [NUM_SETS][NUM_WAYS];
  logic [TAG_W-1:0] ent_tag   [NUM_SETS][NUM_WAYS];
  perm_e            ent_perm  [NUM_SETS][NUM_WAYS];
  logic [CTX_W-1:0] ent_lock  [NUM_SETS][NUM_WAYS];

  // Request decode
  op_e              op;
  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] req_tag;
  logic             unused_offset;

  assign op            = op_e'(req_op);
  assign set_idx       = req_addr[IDX_LSB +: SET_W];
  assign req_tag       = req_addr[ADDR_W-1:IDX_LSB];
  assign unused_offset = ^req_addr[IDX_LSB-1:0];

  // Per-way compare
  logic [NUM_WAYS-1:0] raw_vec, live_vec, free_vec;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    tagdir_way_cmp #(.TAG_W(TAG_W)) u_cmp (
      .way_valid  (ent_valid[set_idx][w]),
      .way_tag    (ent_tag[set_idx][w]),
      .way_perm   (ent_perm[set_idx][w]),
      .req_tag    (req_tag),
      .raw_match  (raw_vec[w]),
      .live_match (live_vec[w]),
      .is_free    (free_vec[w])
    );
  end

  logic             raw_any, live_any, free_any;
  logic [WAY_W-1:0] raw_way, live_way, free_way;

  tagdir_pick_first #(.N(NUM_WAYS)) u_pick_raw  (.vec(raw_vec),  .found(raw_any),  .idx(raw_way));
  tagdir_pick_first #(.N(NUM_WAYS)) u_pick_live (.vec(live_vec), .found(live_any), .idx(live_way));
  tagdir_pick_first #(.N(NUM_WAYS)) u_pick_free (.vec(free_vec), .found(free_any), .idx(free_way));

  // Allocation never duplicates a tag, so at most one raw match exists.
  perm_e            sel_perm;
  logic [CTX_W-1:0] sel_lock;
  assign sel_perm = ent_perm[set_idx][raw_way];
  assign sel_lock = ent_lock[set_idx][live_way];

  logic             alloc_ok;
  logic [WAY_W-1:0] alloc_way;
  assign alloc_ok  = !live_any && (raw_any || free_any);
  assign alloc_way = raw_any ? raw_way : free_way;

  // Replacement order
  logic             touch_en;
  logic [WAY_W-1:0] touch_way;
  logic [WAY_W-1:0] victim_way;

  assign touch_en  = req_valid &&
                     ((op == OP_ACCESS && live_any) ||
                      (op == OP_ALLOC && alloc_ok && req_touch));
  assign touch_way = (op == OP_ACCESS) ? live_way : alloc_way;

  tagdir_lru #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (touch_en),
    .touch_set  (set_idx),
    .touch_way  (touch_way),
    .query_set  (set_idx),
    .victim_way (victim_way)
  );

  // State update
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        for (int w = 0; w < NUM_WAYS; w++) begin
          ent_valid[s][w] <= 1'b0;
          ent_tag[s][w]   <= '0;
          ent_perm[s][w]  <= PERM_NOTPRESENT;
          ent_lock[s][w]  <= NO_OWNER;
        end
      end
    end else if (req_valid) begin
      case (op)
        OP_ALLOC: if (alloc_ok) begin
          ent_valid[set_idx][alloc_way] <= 1'b1;
          ent_tag[set_idx][alloc_way]   <= req_tag;
          ent_perm[set_idx][alloc_way]  <= PERM_INVALID;
          ent_lock[set_idx][alloc_way]  <= NO_OWNER;
        end
        OP_DEALLOC: if (live_any) begin
          ent_valid[set_idx][live_way] <= 1'b0;
          ent_perm[set_idx][live_way]  <= PERM_NOTPRESENT;
        end
        OP_LOCK_SET: if (live_any) ent_lock[set_idx][live_way] <= req_ctx;
        OP_LOCK_CLR: if (live_any) ent_lock[set_idx][live_way] <= NO_OWNER;
        OP_SET_PERM: if (raw_any)  ent_perm[set_idx][raw_way]  <= perm_e'(req_perm);
        default: ;
      endcase
    end
  end

  // Response
  logic              d_hit, d_grant, d_avail, d_error, d_lock, d_nb;
  logic [WAY_W-1:0]  d_way;
  logic [ADDR_W-1:0] d_victim;

  always_comb begin
    d_hit    = 1'b0;
    d_way    = '0;
    d_grant  = 1'b0;
    d_avail  = 1'b0;
    d_error  = 1'b0;
    d_lock   = 1'b0;
    d_nb     = 1'b0;
    d_victim = '0;
    if (req_valid) begin
      case (op)
        OP_ACCESS: begin
          d_hit   = live_any;
          d_grant = live_any && perm_grants(sel_perm, rqtype_e'(req_type));
          d_nb    = raw_any && (sel_perm != PERM_BUSY);
        end
        OP_LOOKUP_RAW: begin
          d_hit = raw_any;
          d_nb  = raw_any && (sel_perm != PERM_BUSY);
        end
        OP_AVAIL:    d_avail = raw_any || free_any;
        OP_ALLOC: begin
          d_error = !alloc_ok;
          if (alloc_ok) d_way = alloc_way;
        end
        OP_PROBE: begin
          d_way    = victim_way;
          d_victim = {ent_tag[set_idx][victim_way], {IDX_LSB{1'b0}}};
        end
        OP_DEALLOC, OP_LOCK_SET, OP_LOCK_CLR: d_hit = live_any;
        OP_LOCK_TEST: begin
          d_hit  = live_any;
          d_lock = live_any && (sel_lock == req_ctx);
        end
        OP_SET_PERM: d_hit = raw_any;
        default: ;
      endcase
      if (d_hit) d_way = raw_way;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid       <= 1'b0;
      rsp_hit         <= 1'b0;
      rsp_way         <= '0;
      rsp_grant       <= 1'b0;
      rsp_avail       <= 1'b0;
      rsp_error       <= 1'b0;
      rsp_lock_match  <= 1'b0;
      rsp_not_busy    <= 1'b0;
      rsp_victim_addr <= '0;
    end else begin
      rsp_valid       <= req_valid;
      rsp_hit         <= d_hit;
      rsp_way         <= d_way;
      rsp_grant       <= d_grant;
      rsp_avail       <= d_avail;
      rsp_error       <= d_error;
      rsp_lock_match  <= d_lock;
      rsp_not_busy    <= d_nb;
      rsp_victim_addr <= d_victim;
    end
  end
endmodule

// File: rtl/permtag_dir_chk.sv
module permtag_dir_chk
  import tagdir_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WAY_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [3:0]        req_op,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [WAY_W-1:0]  rsp_way,
  input logic              rsp_grant,
  input logic              rsp_avail,
  input logic              rsp_error,
  input logic              rsp_lock_match,
  input logic              rsp_not_busy,
  input logic [ADDR_W-1:0] rsp_victim_addr
);
  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_quiet_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_grant || rsp_avail || rsp_error ||
                     rsp_lock_match || rsp_not_busy) &&
                   rsp_way == '0 && rsp_victim_addr == '0);

  p_grant_needs_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_grant |-> rsp_hit);

  p_error_only_alloc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_error |-> $past(req_op) == OP_ALLOC);

  p_lock_only_test_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_lock_match |-> ($past(req_op) == OP_LOCK_TEST) && rsp_hit);

  p_avail_only_query_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_avail |-> $past(req_op) == OP_AVAIL);
endmodule

bind permtag_dir permtag_dir_chk #(.ADDR_W(ADDR_W), .WAY_W(WAY_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_op          (req_op),
  .rsp_valid       (rsp_valid),
  .rsp_hit         (rsp_hit),
  .rsp_way         (rsp_way),
  .rsp_grant       (rsp_grant),
  .rsp_avail       (rsp_avail),
  .rsp_error       (rsp_error),
  .rsp_lock_match  (rsp_lock_match),
  .rsp_not_busy    (rsp_not_busy),
  .rsp_victim_addr (rsp_victim_addr)
);

// File: tb/permtag_dir_tb.sv
module permtag_dir_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 44;

  localparam logic [3:0] ACC = 4'd0, RAW = 4'd1, AVL = 4'd2, ALC = 4'd3, DEA = 4'd4,
                         PRB = 4'd5, LKS = 4'd6, LKC = 4'd7, LKT = 4'd8, SPM = 4'd9;
  localparam logic [1:0] LD = 2'd0, IF = 2'd1, ST = 2'd2, AT = 2'd3;
  localparam logic [2:0] NP = 3'd0, RO = 3'd2, RW = 3'd3, BZ = 3'd4;
  // Set 1 lines with distinct tags; X1 has A1's upper bits but lives in set 2.
  localparam logic [15:0] A1 = 16'h0050, A2 = 16'h0090, A3 = 16'h00D0,
                          A4 = 16'h0110, A5 = 16'h0150, A6 = 16'h0190, X1 = 16'h0060;

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  op;
    logic [15:0] addr;
    logic [1:0]  typ;
    logic [3:0]  ctx;
    logic [2:0]  perm;
    logic        touch;
    logic        hit;
    logic [1:0]  way;
    logic        grant;
    logic        avail;
    logic        err;
    logic        lock;
    logic        nb;
    logic [15:0] vic;
  } vec_t;

  //                req op   addr typ ctx perm t  h way g a e l nb vic
  localparam vec_t VECS [NV] = '{
    '{7,  ALC, A1, LD, 0, NP, 1, 0, 0, 0,0,0,0,0, 16'h0},     // R7 first free way 0
    '{3,  ACC, A1, LD, 0, NP, 0, 1, 0, 0,0,0,0,1, 16'h0},     // R3 invalid still hits
    '{12, SPM, A1, LD, 0, RO, 0, 1, 0, 0,0,0,0,0, 16'h0},     // R12
    '{4,  ACC, A1, LD, 0, NP, 0, 1, 0, 1,0,0,0,1, 16'h0},     // R4 RO load
    '{4,  ACC, A1, ST, 0, NP, 0, 1, 0, 0,0,0,0,1, 16'h0},     // R4 RO store denied
    '{4,  ACC, A1, IF, 0, NP, 0, 1, 0, 1,0,0,0,1, 16'h0},     // R4 RO ifetch
    '{12, SPM, A1, LD, 0, RW, 0, 1, 0, 0,0,0,0,0, 16'h0},     // R12
    '{4,  ACC, A1, ST, 0, NP, 0, 1, 0, 1,0,0,0,1, 16'h0},     // R4 RW store
    '{4,  ACC, A1, AT, 0, NP, 0, 1, 0, 1,0,0,0,1, 16'h0},     // R4 RW atomic
    '{7,  ALC, A2, LD, 0, NP, 0, 0, 1, 0,0,0,0,0, 16'h0},     // R7
    '{7,  ALC, A3, LD, 0, NP, 1, 0, 2, 0,0,0,0,0, 16'h0},     // R7 touching
    '{7,  ALC, A4, LD, 0, NP, 0, 0, 3, 0,0,0,0,0, 16'h0},     // R7 set now full
    '{6,  AVL, A5, LD, 0, NP, 0, 0, 0, 0,0,0,0,0, 16'h0},     // R6 full, absent
    '{6,  AVL, A3, LD, 0, NP, 0, 0, 0, 0,1,0,0,0, 16'h0},     // R6 already present
    '{7,  ALC, A5, LD, 0, NP, 1, 0, 0, 0,0,1,0,0, 16'h0},     // R7 no free way
    '{11, PRB, A5, LD, 0, NP, 0, 0, 3, 0,0,0,0,0, A4},        // R11 untouched alloc is LRU
    '{5,  ACC, A4, LD, 0, NP, 0, 1, 3, 0,0,0,0,1, 16'h0},     // R5 denied hit touches
    '{11, PRB, A5, LD, 0, NP, 0, 0, 1, 0,0,0,0,0, A2},        // R11
    '{12, SPM, A2, LD, 0, NP, 0, 1, 1, 0,0,0,0,0, 16'h0},     // R12 to NOTPRESENT
    '{3,  ACC, A2, LD, 0, NP, 0, 0, 0, 0,0,0,0,1, 16'h0},     // R3 NP not a hit
    '{3,  RAW, A2, LD, 0, NP, 0, 1, 1, 0,0,0,0,1, 16'h0},     // R3 raw lookup
    '{6,  AVL, A5, LD, 0, NP, 0, 0, 0, 0,1,0,0,0, 16'h0},     // R6 NP way free
    '{7,  ALC, A5, LD, 0, NP, 1, 0, 1, 0,0,0,0,0, 16'h0},     // R7 reuse NP way
    '{11, PRB, A5, LD, 0, NP, 0, 0, 0, 0,0,0,0,0, A1},        // R11
    '{12, SPM, A3, LD, 0, BZ, 0, 1, 2, 0,0,0,0,0, 16'h0},     // R12 busy
    '{10, ACC, A3, LD, 0, NP, 0, 1, 2, 0,0,0,0,0, 16'h0},     // R10 busy line
    '{10, RAW, A1, LD, 0, NP, 0, 1, 0, 0,0,0,0,1, 16'h0},     // R10
    '{5,  PRB, A1, LD, 0, NP, 0, 0, 0, 0,0,0,0,0, A1},        // R5 order after busy hit
    '{9,  LKT, A5, LD, 15,NP, 0, 1, 1, 0,0,0,1,0, 16'h0},     // R9 alloc clears owner
    '{9,  LKS, A5, LD, 3, NP, 0, 1, 1, 0,0,0,0,0, 16'h0},     // R9
    '{9,  LKT, A5, LD, 3, NP, 0, 1, 1, 0,0,0,1,0, 16'h0},     // R9
    '{9,  LKT, A5, LD, 4, NP, 0, 1, 1, 0,0,0,0,0, 16'h0},     // R9 other ctx
    '{9,  LKC, A5, LD, 0, NP, 0, 1, 1, 0,0,0,0,0, 16'h0},     // R9
    '{9,  LKT, A5, LD, 3, NP, 0, 1, 1, 0,0,0,0,0, 16'h0},     // R9 cleared
    '{8,  DEA, A1, LD, 0, NP, 0, 1, 0, 0,0,0,0,0, 16'h0},     // R8
    '{8,  RAW, A1, LD, 0, NP, 0, 0, 0, 0,0,0,0,0, 16'h0},     // R8 gone
    '{8,  ACC, A1, LD, 0, NP, 0, 0, 0, 0,0,0,0,0, 16'h0},     // R8 gone
    '{7,  ALC, A6, LD, 0, NP, 0, 0, 0, 0,0,0,0,0, 16'h0},     // R7 emptied way 0
    '{1,  ACC, X1, LD, 0, NP, 0, 0, 0, 0,0,0,0,0, 16'h0},     // R1 other set
    '{1,  AVL, X1, LD, 0, NP, 0, 0, 0, 0,1,0,0,0, 16'h0},     // R1
    '{1,  ALC, X1, LD, 0, NP, 0, 0, 0, 0,0,0,0,0, 16'h0},     // R1 set 2 way 0
    '{7,  ALC, A6, LD, 0, NP, 0, 0, 0, 0,0,1,0,0, 16'h0},     // R7 already present
    '{8,  DEA, A1, LD, 0, NP, 0, 0, 0, 0,0,0,0,0, 16'h0},     // R8 absent dealloc
    '{11, PRB, A6, LD, 0, NP, 0, 0, 0, 0,0,0,0,0, A6}         // R11 dealloc keeps order
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_op = '0;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_type = '0;
  logic [3:0]  req_ctx = '0;
  logic [2:0]  req_perm = '0;
  logic        req_touch = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_grant, rsp_avail, rsp_error, rsp_lock_match, rsp_not_busy;
  logic [1:0]  rsp_way;
  logic [15:0] rsp_victim_addr;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  permtag_dir u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_type(req_type), .req_ctx(req_ctx),
    .req_perm(req_perm), .req_touch(req_touch), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_grant(rsp_grant),
    .rsp_avail(rsp_avail), .rsp_error(rsp_error), .rsp_lock_match(rsp_lock_match),
    .rsp_not_busy(rsp_not_busy), .rsp_victim_addr(rsp_victim_addr)
  );

  function automatic logic [24:0] got_word();
    return {rsp_valid, rsp_hit, rsp_way, rsp_grant, rsp_avail, rsp_error,
            rsp_lock_match, rsp_not_busy, rsp_victim_addr};
  endfunction

  task automatic check(input string tag, input logic [24:0] exp);
    logic [24:0] got;
    got = got_word();
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Drive one request for one cycle; the response is registered at that edge.
  task automatic issue(input logic [3:0] op, input logic [15:0] addr, input logic [1:0] typ,
                       input logic [3:0] ctx, input logic [2:0] perm, input logic touch);
    @(negedge clk);
    req_op = op; req_addr = addr; req_type = typ;
    req_ctx = ctx; req_perm = perm; req_touch = touch;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset state", 25'h0);
    rst_n = 1'b1;

    // Walk the vector table
    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].op, VECS[i].addr, VECS[i].typ, VECS[i].ctx, VECS[i].perm, VECS[i].touch);
      check($sformatf("R%0d row %0d", VECS[i].req, i),
            {1'b1, VECS[i].hit, VECS[i].way, VECS[i].grant, VECS[i].avail, VECS[i].err,
             VECS[i].lock, VECS[i].nb, VECS[i].vic});
    end

    // R2: inputs held without req_valid produce nothing and change nothing
    @(negedge clk);
    req_op = ALC; req_addr = 16'h01D0; req_touch = 1'b1;
    @(negedge clk);
    check("R2 idle no response", 25'h0);
    issue(RAW, 16'h01D0, LD, 0, NP, 0);
    check("R2 idle left state", {1'b1, 24'h0});

    // R3: undefined opcode returns an empty response
    issue(4'd12, A5, LD, 0, NP, 0);
    check("R3 undefined op", {1'b1, 24'h0});

    // R1: low offset bits ignored
    issue(RAW, A5 | 16'h000F, LD, 0, NP, 0);
    check("R1 offset ignored", {1'b1, 1'b1, 2'd1, 5'b00001, 16'h0});

    // R2: reset empties every way and restores LRU order
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    issue(RAW, A5, LD, 0, NP, 0);
    check("R2 reset clears lines", {1'b1, 24'h0});
    issue(PRB, A5, LD, 0, NP, 0);
    check("R11 probe after reset", {1'b1, 1'b0, 2'd3, 5'b0, 16'h0});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule